// File: doc/BRIEF.md
# Sleep-Period Timer and Host Wake Controller

This block runs beside a small sequencer core. It decides when the core is restarted after it stops, and it decides how the core's request for attention reaches the host. The host can program five sleep-period slots. The core chooses one of them at runtime with a select strobe. Each time the core halts, the chosen period is loaded into a down-counter. When that counter expires, the block sends a single-cycle start pulse back to the core. The host can turn these automatic restarts off with an enable bit. Once it does, a halted core stays stopped until the host starts it by other means.

The core can also issue a wake strobe. The power controller may report that it is not ready for wakeup; in that case the strobe is discarded without any trace. When the controller is ready, the strobe is routed by the chip's state. In deep sleep, with core wake-up allowed, it becomes a one-cycle wake request. Outside deep sleep, with the core interrupt enabled, it sets a sticky interrupt bit, which the host clears with a write-one-to-clear strobe.

Top module: `lp_wake_ctrl`

## Requirements
- R1: After synchronous reset, `core_start`, `wake_req` and `irq` are low, every period slot holds `RST_PERIOD`, and slot 0 is the selected slot.
- R2: A host write with `cfg_idx` in 0..4 stores `cfg_period` into that slot. A write with `cfg_idx` of 5..7 changes no slot.
- R3: A `core_sel` strobe with `core_sel_idx` in 0..4 makes that slot the one loaded by every later halt.
- R4: A `core_sel` strobe with `core_sel_idx` of 5..7 is ignored, and the previous selection stays in force.
- R5: Suppose `core_halt` is sampled high with `tmr_en` high on some clock edge, and the selected slot holds P. Then `core_start` is high for exactly one cycle, starting with the (P+1)-th rising edge after that edge. P may be anything from 0 to 2^PERIOD_W-1.
- R6: A halt sampled while `tmr_en` is low does not start the timer. Taking `tmr_en` low while the count is in progress cancels it, and no start pulse follows.
- R7: A halt that arrives while a count is in progress reloads the full selected period, and timing restarts from the new halt.
- R8: A `core_wake` strobe with `rdy_wake`, `deep_sleep` and `wake_en` all high drives `wake_req` high for the single cycle after the strobe's edge.
- R9: A `core_wake` strobe with `rdy_wake` high, `deep_sleep` low and `irq_en` high sets `irq`, and `irq` stays high until it is cleared. If `irq_en` is low, the strobe leaves `irq` low.
- R10: A `core_wake` strobe with `rdy_wake` low raises neither `wake_req` nor `irq`.
- R11: An `irq_clr` strobe clears `irq`. If a new interrupt is set on the same edge, the set wins.
- R12: After its start pulse, the timer stays idle and gives no further pulse until the next halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Host write strobe for a period slot |
| cfg_idx | input | 3 | Slot index for the host write |
| cfg_period | input | PERIOD_W | Period value to store |
| core_halt | input | 1 | Core halted strobe |
| core_sel | input | 1 | Core slot-select strobe |
| core_sel_idx | input | 3 | Slot index requested by the core |
| core_wake | input | 1 | Core wake strobe |
| tmr_en | input | 1 | Automatic restart enable |
| deep_sleep | input | 1 | Chip is in deep sleep |
| wake_en | input | 1 | Core may wake the chip from deep sleep |
| rdy_wake | input | 1 | Power controller ready for wakeup |
| irq_en | input | 1 | Core interrupt enable |
| irq_clr | input | 1 | Write-one-to-clear strobe for the interrupt |
| core_start | output | 1 | One-cycle restart pulse to the core |
| wake_req | output | 1 | One-cycle wake request to the power controller |
| irq | output | 1 | Sticky core interrupt |

## Verification
The bench builds the block with `PERIOD_W` = 6 and `RST_PERIOD` = 3. With these values the largest period, 63, takes only 64 cycles, so the counter's full range and the zero period can both be timed exactly. The reset value is non-zero, so it shows up in the measured latency. Each slot is given a different period, so the start latency alone tells which slot is selected. This lets both the ignored select indices and the ignored write indices be observed at the ports.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    localparam int NUM_SLOTS = 5;
    localparam int SEL_W     = 3;

    typedef logic [SEL_W-1:0] slot_idx_t;

    // Chip state that steers a wake strobe
    typedef struct packed {
        logic rdy;
        logic deep;
        logic wake_ok;
        logic irq_ok;
    } wake_env_t;

    function automatic logic slot_valid(input slot_idx_t idx);
        return int'(idx) < NUM_SLOTS;
    endfunction

endpackage

// File: rtl/lpw_period_bank.sv
module lpw_period_bank
    import lpw_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int RST_PERIOD = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  slot_idx_t           cfg_idx,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic                core_sel,
    input  slot_idx_t           core_sel_idx,
    output logic [PERIOD_W-1:0] sel_period
);

    localparam logic [PERIOD_W-1:0] RST_VAL = PERIOD_W'(RST_PERIOD);

    logic [PERIOD_W-1:0] bank [NUM_SLOTS];
    slot_idx_t           sel_q;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic [PERIOD_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= RST_VAL;
            else if (cfg_wr && cfg_idx == slot_idx_t'(s))
                slot_q <= cfg_period;
        end
        assign bank[s] = slot_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            sel_q <= '0;
        else if (core_sel && slot_valid(core_sel_idx))
            sel_q <= core_sel_idx;
    end

    always_comb begin
        sel_period = '0;
        for (int s = 0; s < NUM_SLOTS; s++)
            if (sel_q == slot_idx_t'(s))
                sel_period = bank[s];
    end

    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
        slot_valid(sel_q)); // R4
    AST_SEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (core_sel && !slot_valid(core_sel_idx)) |=> $stable(sel_q)); // R4

endmodule

// File: rtl/lpw_countdown.sv
module lpw_countdown #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tmr_en,
    input  logic                core_halt,
    input  logic [PERIOD_W-1:0] load_val,
    output logic                core_start
);

    logic [PERIOD_W-1:0] cnt_q;
    logic                run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q      <= '0;
            run_q      <= 1'b0;
            core_start <= 1'b0;
        end else begin
            core_start <= 1'b0;
            if (!tmr_en) begin
                run_q <= 1'b0;
            end else if (core_halt) begin
                cnt_q <= load_val;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    core_start <= 1'b1;
                    run_q      <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
        end
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start); // R5
    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
        !tmr_en |=> !core_start); // R6
    AST_HALT_RELOADS: assert property (@(posedge clk) disable iff (rst)
        (core_halt && tmr_en) |=> !core_start); // R7
    AST_IDLE_AFTER_START: assert property (@(posedge clk) disable iff (rst)
        (core_start && !core_halt) |=> !run_q); // R12

endmodule

// File: rtl/lpw_wake_router.sv
module lpw_wake_router
    import lpw_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      core_wake,
    input  wake_env_t env,
    input  logic      irq_clr,
    output logic      wake_req,
    output logic      irq
);

    logic wake_go;
    assign wake_go = core_wake && env.rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_req <= 1'b0;
            irq      <= 1'b0;
        end else begin
            wake_req <= wake_go && env.deep && env.wake_ok;
            irq      <= (wake_go && !env.deep && env.irq_ok) || (irq && !irq_clr);
        end
    end

    AST_WAKE_NEEDS_READY: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_req) |-> $past(env.rdy && core_wake)); // R10
    AST_WAKE_IN_DEEP: assert property (@(posedge clk) disable iff (rst)
        $rose(wake_req) |-> $past(env.deep)); // R8
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_clr) |=> irq); // R9
    AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
        (irq_clr && !core_wake) |=> !irq); // R11

endmodule

// File: rtl/lp_wake_ctrl.sv
module lp_wake_ctrl
    import lpw_pkg::*;
#(
    parameter int PERIOD_W   = 16,
    parameter int RST_PERIOD = 0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_wr,
    input  logic [2:0]          cfg_idx,
    input  logic [PERIOD_W-1:0] cfg_period,
    input  logic                core_halt,
    input  logic                core_sel,
    input  logic [2:0]          core_sel_idx,
    input  logic                core_wake,
    input  logic                tmr_en,
    input  logic                deep_sleep,
    input  logic                wake_en,
    input  logic                rdy_wake,
    input  logic                irq_en,
    input  logic                irq_clr,
    output logic                core_start,
    output logic                wake_req,
    output logic                irq
);

    logic [PERIOD_W-1:0] sel_period;
    wake_env_t           env;

    assign env = '{rdy: rdy_wake, deep: deep_sleep, wake_ok: wake_en, irq_ok: irq_en};

    lpw_period_bank #(.PERIOD_W(PERIOD_W), .RST_PERIOD(RST_PERIOD)) u_bank (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_idx      (cfg_idx),
        .cfg_period   (cfg_period),
        .core_sel     (core_sel),
        .core_sel_idx (core_sel_idx),
        .sel_period   (sel_period)
    );

    lpw_countdown #(.PERIOD_W(PERIOD_W)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .tmr_en     (tmr_en),
        .core_halt  (core_halt),
        .load_val   (sel_period),
        .core_start (core_start)
    );

    lpw_wake_router u_wake (
        .clk       (clk),
        .rst       (rst),
        .core_wake (core_wake),
        .env       (env),
        .irq_clr   (irq_clr),
        .wake_req  (wake_req),
        .irq       (irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (!core_start && !wake_req && !irq)); // R1

endmodule

// File: tb/test_lp_wake_ctrl.sv
module test_lp_wake_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int PW         = 6;
    localparam int RSTP       = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_wr = 0, core_halt = 0, core_sel = 0, core_wake = 0;
    logic [2:0]    cfg_idx = 0, core_sel_idx = 0;
    logic [PW-1:0] cfg_period = 0;
    logic          tmr_en = 0, deep_sleep = 0, wake_en = 0, rdy_wake = 0;
    logic          irq_en = 0, irq_clr = 0;
    logic          core_start, wake_req, irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lp_wake_ctrl #(.PERIOD_W(PW), .RST_PERIOD(RSTP)) i_lp_wake_ctrl (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_period(cfg_period), .core_halt(core_halt), .core_sel(core_sel),
        .core_sel_idx(core_sel_idx), .core_wake(core_wake), .tmr_en(tmr_en),
        .deep_sleep(deep_sleep), .wake_en(wake_en), .rdy_wake(rdy_wake),
        .irq_en(irq_en), .irq_clr(irq_clr), .core_start(core_start),
        .wake_req(wake_req), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic host_write(input int idx, input int val);
        cfg_wr = 1; cfg_idx = 3'(idx); cfg_period = PW'(val);
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic select(input int idx);
        core_sel = 1; core_sel_idx = 3'(idx);
        @(negedge clk);
        core_sel = 0;
    endtask

    task automatic halt();
        core_halt = 1;
        @(negedge clk);
        core_halt = 0;
    endtask

    // Negedges after the halt until core_start is seen (0 if none within limit)
    task automatic measure(input int limit, output int lat);
        lat = 0;
        for (int n = 0; n <= limit; n++) begin
            if (core_start) begin lat = n; break; end
            @(negedge clk);
        end
    endtask

    // Halt, time the pulse, then confirm it is single and not repeated
    task automatic timed_run(input string req, input int exp_lat);
        int lat;
        int extra;
        halt();
        measure(80, lat);
        check(req, lat, exp_lat);
        extra = 0;
        for (int n = 0; n < 70; n++) begin
            @(negedge clk);
            if (core_start) extra++;
        end
        check("R12 no repeat start", extra, 0);
    endtask

    task automatic t_reset();
        check("R1 core_start", int'(core_start), 0);
        check("R1 wake_req", int'(wake_req), 0);
        check("R1 irq", int'(irq), 0);
        tmr_en = 1;
        timed_run("R1 default slot0 reset period", RSTP + 1);
    endtask

    task automatic t_select();
        for (int s = 0; s < 5; s++) host_write(s, 5 + 4 * s);
        timed_run("R2 slot0 written", 6);
        select(2);
        timed_run("R3 select slot2", 14);
        select(4);
        timed_run("R3 select slot4", 22);
        select(6);
        timed_run("R4 index 6 ignored", 22);
        select(5);
        timed_run("R4 index 5 ignored", 22);
        host_write(7, 40);
        timed_run("R2 write idx7 ignored", 22);
        host_write(4, 30);
        timed_run("R2 slot4 rewritten", 31);
    endtask

    task automatic t_bounds();
        host_write(1, 0);
        host_write(3, 63);
        select(1);
        timed_run("R5 zero period", 1);
        select(3);
        timed_run("R5 max period", 64);
    endtask

    task automatic t_disable();
        int lat;
        select(2);
        tmr_en = 0;
        halt();
        measure(40, lat);
        check("R6 halt while disabled", lat, 0);
        tmr_en = 1;
        halt();
        repeat (3) @(negedge clk);
        tmr_en = 0;
        measure(40, lat);
        check("R6 cancel by disable", lat, 0);
        tmr_en = 1;
        measure(40, lat);
        check("R6 stays halted after re-enable", lat, 0);
    endtask

    task automatic t_restart();
        int lat;
        halt();
        repeat (5) @(negedge clk);
        check("R7 no start before restart", int'(core_start), 0);
        halt();
        measure(40, lat);
        check("R7 restart full period", lat, 14);
    endtask

    task automatic wake_pulse();
        core_wake = 1;
        @(negedge clk);
        core_wake = 0;
    endtask

    task automatic t_wake();
        rdy_wake = 1; deep_sleep = 1; wake_en = 1; irq_en = 1;
        wake_pulse();
        check("R8 wake_req high", int'(wake_req), 1);
        check("R8 no irq in deep sleep", int'(irq), 0);
        @(negedge clk);
        check("R8 wake_req single cycle", int'(wake_req), 0);
        wake_en = 0;
        wake_pulse();
        check("R8 wake disabled", int'(wake_req), 0);
        wake_en = 1; rdy_wake = 0;
        wake_pulse();
        check("R10 not ready no wake", int'(wake_req), 0);
        deep_sleep = 0;
        wake_pulse();
        check("R10 not ready no irq", int'(irq), 0);
        rdy_wake = 1; irq_en = 0;
        wake_pulse();
        check("R9 irq masked", int'(irq), 0);
        irq_en = 1;
        wake_pulse();
        check("R9 irq set", int'(irq), 1);
        check("R9 no wake_req awake", int'(wake_req), 0);
        repeat (4) @(negedge clk);
        check("R9 irq sticky", int'(irq), 1);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
        check("R11 irq cleared", int'(irq), 0);
        irq_clr = 1; core_wake = 1;
        @(negedge clk);
        irq_clr = 0; core_wake = 0;
        check("R11 set wins over clear", int'(irq), 1);
        irq_clr = 1;
        @(negedge clk);
        irq_clr = 0;
    endtask

    bit finished = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_select();
        t_bounds();
        t_disable();
        t_restart();
        t_wake();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule